// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block expands one supplied address into a short burst of addresses for a synchronous memory port. When the step/load control is low on an enabled clock edge, the whole input address is captured and becomes the first beat of a burst. On each later enabled edge with the step/load control high, the input address is ignored and the burst moves one beat forward. Only the low-order offset bits change. The bits above the offset stay fixed for the whole burst.

The ordering of the offset bits is picked when the address is loaded. The XOR order produces the start offset XORed with the beat number. The linear order adds the beat number to the start offset, wrapping at the group size. An active-low clock enable freezes all state. The default group is four beats, so the offset is two bits wide. The outputs come straight from registers and from a small mux, so each new address shows up in the cycle right after the edge that caused it.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rstN low at a rising edge) clears the captured address and the beat index, so addrOut and beatIdx both read zero after that edge.
- R2: On a rising edge with clkEnN low and stepNotLoad low, addrIn is captured. After that edge, addrOut equals addrIn and beatIdx is 0.
- R3: On a rising edge with clkEnN low and stepNotLoad high, addrIn has no effect and beatIdx increments by one, modulo 4.
- R4: If linearMode was 0 at the load edge, the low two bits of addrOut equal the start offset XOR beatIdx. For a start of 2'b10 this gives 10, 11, 00, 01.
- R5: If linearMode was 1 at the load edge, the low two bits of addrOut equal (start offset + beatIdx) mod 4. For a start of 2'b11 this gives 11, 00, 01, 10.
- R6: addrOut bits above bit 1 never change on a step. After the fourth beat, further steps wrap inside the same four-address group, with no carry or borrow into the upper bits.
- R7: On a rising edge with clkEnN high, addrOut and beatIdx hold, whatever addrIn, stepNotLoad and linearMode are.
- R8: linearMode is sampled only at the load edge. Changing it during step cycles does not change the ordering of the current burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low. When high, the edge is ignored |
| stepNotLoad | input | 1 | 0 loads addrIn. 1 advances the burst |
| linearMode | input | 1 | Order chosen at load: 1 linear, 0 XOR |
| addrIn | input | ADDR_W | Address supplied for a load |
| addrOut | output | ADDR_W | Current burst address |
| beatIdx | output | $clog2(BURST_BEATS) | Beat number within the burst |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. Loads, steps, holds and resets all change registers only, and the outputs follow those registers through combinational logic. The bench therefore drives inputs on the falling edge and compares addrOut and beatIdx at the next falling edge. At that point the one rising edge in between has been applied and nothing else has changed. Expected values in the vector table are worked out by hand from the XOR and linear rules, including wraps past the fourth beat and hold cycles placed in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Ordering of the offset bits, fixed at load time
  typedef enum logic {
    ORDER_XOR    = 1'b0,
    ORDER_LINEAR = 1'b1
  } orderE;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } strobeT;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEnN,
  input  logic             stepNotLoad,
  input  logic             linearMode,
  output strobeT           strobes,
  output logic [OFS_W-1:0] beat,
  output orderE            order
);

  logic [OFS_W-1:0] beatQ;
  orderE            orderQ;

  // Decode the enable and the step/load control into strobes
  always_comb begin
    strobes.load = !clkEnN && !stepNotLoad;
    strobes.step = !clkEnN &&  stepNotLoad;
  end

  // Beat counter wraps naturally at 2**OFS_W (R3, R6)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatQ  <= '0;
      orderQ <= ORDER_XOR;
    end else if (strobes.load) begin
      beatQ  <= '0;
      orderQ <= linearMode ? ORDER_LINEAR : ORDER_XOR;  // R8: sampled here only
    end else if (strobes.step) begin
      beatQ  <= beatQ + 1'b1;
    end
  end

  assign beat  = beatQ;
  assign order = orderQ;

endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [OFS_W-1:0]  beat,
  input  orderE             order,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int UPPER_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] baseQ;
  logic [OFS_W-1:0]  startOfs;
  logic [OFS_W-1:0]  seqOfs;

  // Captured start address (R1, R2)
  always_ff @(posedge clk) begin
    if (!rstN)             baseQ <= '0;
    else if (strobes.load) baseQ <= addrIn;
  end

  assign startOfs = baseQ[OFS_W-1:0];

  // Offset ordering (R4, R5). The sum is truncated to OFS_W, so it wraps in the group
  always_comb begin
    unique case (order)
      ORDER_LINEAR: seqOfs = startOfs + beat;
      default:      seqOfs = startOfs ^ beat;
    endcase
  end

  // Upper bits taken straight from the register (R6)
  generate
    if (UPPER_W > 0) begin : g_upper
      assign addrOut = {baseQ[ADDR_W-1:OFS_W], seqOfs};
    end else begin : g_noupper
      assign addrOut = seqOfs;
    end
  endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BURST_BEATS = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           clkEnN,
  input  logic                           stepNotLoad,
  input  logic                           linearMode,
  input  logic [ADDR_W-1:0]              addrIn,
  output logic [ADDR_W-1:0]              addrOut,
  output logic [$clog2(BURST_BEATS)-1:0] beatIdx
);

  localparam int OFS_W = $clog2(BURST_BEATS);

  strobeT           strobes;
  logic [OFS_W-1:0] beat;
  orderE            burstOrder;

  burst_seq_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clkEnN     (clkEnN),
    .stepNotLoad(stepNotLoad),
    .linearMode (linearMode),
    .strobes    (strobes),
    .beat       (beat),
    .order      (burstOrder)
  );

  burst_seq_datapath #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .beat   (beat),
    .order  (burstOrder),
    .addrIn (addrIn),
    .addrOut(addrOut)
  );

  assign beatIdx = beat;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              stepNotLoad,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] addrOut,
  input logic [OFS_W-1:0]  beatIdx,
  input logic              orderLinear
);

  logic loadNow, stepNow;
  assign loadNow = !clkEnN && !stepNotLoad;
  assign stepNow = !clkEnN &&  stepNotLoad;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    loadNow |=> (addrOut == $past(addrIn)) && (beatIdx == '0)); // R2

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stepNow |=> beatIdx == $past(beatIdx) + 1'b1); // R3

  AST_XOR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && !orderLinear) |=>
      (addrOut[OFS_W-1:0] ^ beatIdx) == $past(addrOut[OFS_W-1:0] ^ beatIdx)); // R4

  AST_LINEAR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && orderLinear) |=>
      addrOut[OFS_W-1:0] == $past(addrOut[OFS_W-1:0]) + 1'b1); // R5

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    stepNow |=> addrOut[ADDR_W-1:OFS_W] == $past(addrOut[ADDR_W-1:OFS_W])); // R6

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(addrOut) && $stable(beatIdx)); // R7

  AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    !loadNow |=> $stable(orderLinear)); // R8

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clkEnN     (clkEnN),
  .stepNotLoad(stepNotLoad),
  .addrIn     (addrIn),
  .addrOut    (addrOut),
  .beatIdx    (beatIdx),
  .orderLinear(burstOrder == burst_seq_pkg::ORDER_LINEAR)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 16;
  localparam int NVEC       = 20;

  typedef struct packed {
    logic          enN;
    logic          stp;
    logic          lin;
    logic [AW-1:0] a;
    logic [AW-1:0] expA;
    logic [1:0]    expB;
    logic [3:0]    req;
  } vecT;

  // R2 load, R3 step, R4 XOR order, R5 linear order, R6 wrap/upper bits, R7 hold, R8 mode latch
  localparam vecT VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 16'hABCE, 16'hABCE, 2'd0, 4'd2}, // R2 load XOR, start 10
    '{1'b0, 1'b1, 1'b0, 16'h1111, 16'hABCF, 2'd1, 4'd4}, // R4 11
    '{1'b0, 1'b1, 1'b0, 16'h2222, 16'hABCC, 2'd2, 4'd4}, // R4 00
    '{1'b0, 1'b1, 1'b0, 16'h3333, 16'hABCD, 2'd3, 4'd3}, // R3 01, addrIn ignored
    '{1'b0, 1'b1, 1'b0, 16'h4444, 16'hABCE, 2'd0, 4'd6}, // R6 wrap to start
    '{1'b1, 1'b0, 1'b1, 16'h5555, 16'hABCE, 2'd0, 4'd7}, // R7 hold despite load request
    '{1'b0, 1'b0, 1'b1, 16'h1237, 16'h1237, 2'd0, 4'd2}, // R2 load linear, start 11
    '{1'b0, 1'b1, 1'b0, 16'h0000, 16'h1234, 2'd1, 4'd8}, // R8 mode pin flipped, still linear
    '{1'b0, 1'b1, 1'b0, 16'h0000, 16'h1235, 2'd2, 4'd5}, // R5 01
    '{1'b1, 1'b1, 1'b0, 16'h0000, 16'h1235, 2'd2, 4'd7}, // R7 hold mid burst
    '{1'b0, 1'b1, 1'b1, 16'h0000, 16'h1236, 2'd3, 4'd5}, // R5 10
    '{1'b0, 1'b1, 1'b0, 16'h0000, 16'h1237, 2'd0, 4'd6}, // R6 wraps in group
    '{1'b0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 2'd0, 4'd2}, // R2 load XOR, start 11
    '{1'b0, 1'b1, 1'b1, 16'h0000, 16'hFFFE, 2'd1, 4'd4}, // R4 10
    '{1'b0, 1'b1, 1'b1, 16'h0000, 16'hFFFD, 2'd2, 4'd4}, // R4 01
    '{1'b0, 1'b1, 1'b1, 16'h0000, 16'hFFFC, 2'd3, 4'd4}, // R4 00
    '{1'b0, 1'b1, 1'b1, 16'h0000, 16'hFFFF, 2'd0, 4'd6}, // R6 no carry out of group
    '{1'b0, 1'b0, 1'b1, 16'h0002, 16'h0002, 2'd0, 4'd2}, // R2 load linear, start 10
    '{1'b0, 1'b1, 1'b0, 16'h0000, 16'h0003, 2'd1, 4'd5}, // R5 11
    '{1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 2'd2, 4'd6}  // R6 wrap 11->00, upper unchanged
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic          clkEnN;
  logic          stepNotLoad;
  logic          linearMode;
  logic [AW-1:0] addrIn;
  logic [AW-1:0] addrOut;
  logic [1:0]    beatIdx;

  int testsRun    = 0;
  int testsFailed = 0;
  bit finished    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_BEATS(4)) u_burst_addr_seq (
    .clk        (clk),
    .rstN       (rstN),
    .clkEnN     (clkEnN),
    .stepNotLoad(stepNotLoad),
    .linearMode (linearMode),
    .addrIn     (addrIn),
    .addrOut    (addrOut),
    .beatIdx    (beatIdx)
  );

  task automatic checkOut(input string tag, input logic [AW-1:0] ea, input logic [1:0] eb);
    testsRun++;
    if (addrOut !== ea || beatIdx !== eb) begin
      testsFailed++;
      $display("FAIL %s: addrOut=%h beatIdx=%0d expected addrOut=%h beatIdx=%0d",
               tag, addrOut, beatIdx, ea, eb);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    rstN = 1'b0; clkEnN = 1'b0; stepNotLoad = 1'b0; linearMode = 1'b0; addrIn = 16'hDEAD;
    repeat (3) @(negedge clk);
    checkOut("R1 reset state", 16'h0000, 2'd0);
    rstN = 1'b1; clkEnN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      clkEnN      = VECS[i].enN;
      stepNotLoad = VECS[i].stp;
      linearMode  = VECS[i].lin;
      addrIn      = VECS[i].a;
      @(negedge clk);
      checkOut($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].expA, VECS[i].expB);
    end

    // R1: reset in the middle of a burst
    clkEnN = 1'b0; stepNotLoad = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkOut("R1 reset mid burst", 16'h0000, 2'd0);

    // R3: after reset, steps run from offset zero in XOR order
    rstN = 1'b1; stepNotLoad = 1'b1; addrIn = 16'h7777;
    @(negedge clk);
    checkOut("R3 step after reset", 16'h0001, 2'd1);

    finish();
  end

endmodule